// File: doc/BRIEF.md
# Multi-Way Address Translation Matcher

This block is the lookup core of an address translation buffer. It holds several ways that are searched side by side. Each way has a small array of entries. Every entry stores a valid bit, a virtual page base, a physical page base, an address-space tag and a 4-bit memory attribute. A lookup request carries a virtual address and the current address-space tag. The request is registered. In the next cycle every way picks one entry, using the address bits just above that way's page offset, and compares it with the request. The block then reports exactly one of three results: hit, miss or multihit. On a hit it also returns the translated physical address and the attribute.

Each way has its own page size, and that size can be changed at run time. A configuration register holds a 4-bit slot number for each of the first eight ways. Each slot number selects one entry from a list of supported page sizes. A list entry of zero means that size is not supported. Selecting such a slot raises a configuration error, and the way involved never hits. Ways numbered eight and above always use slot 0. Software fills entries through a write port and removes them through an invalidate port. Both ports pick the entry with the same index rule that lookup uses.

Top module: `tlb_matcher`

## Requirements
- R1: After reset no entry is valid, every configuration slot is 0, `rsp_valid` is low and `cfg_err` is low; a lookup issued right after reset reports a miss.
- R2: When exactly one way matches, the response has `rsp_hit`=1, `rsp_miss`=0 and `rsp_multihit`=0. `rsp_pa` takes the stored physical page bits above that way's page offset and the request's address bits below it, and `rsp_ca` is the stored attribute.
- R3: When no way matches, the response has `rsp_miss`=1 and `rsp_pa`=0 and `rsp_ca`=0. No way matches when the address-space tag differs from the stored one, or when the page bits above the offset differ, or when the indexed entry is invalid.
- R4: When two or more ways match, the response has `rsp_multihit`=1 with `rsp_hit`=0, `rsp_miss`=0, `rsp_pa`=0 and `rsp_ca`=0.
- R5: An address-space tag of 0 never matches, even against an entry that was written with tag 0.
- R6: A way selects its entry from the address bits just above its page offset: bits [lg+1:lg] with the default 4 entries, where 2^lg is the page size. Entries at different indices of one way are resident at the same time.
- R7: Way n takes its page size from configuration bits [4n+3:4n], which give a slot number. The default slots are 0→4 KiB (lg 12), 1→16 KiB, 2→64 KiB and 4→1 MiB. The configuration register is written with `cfg_we`, and the new value takes effect from the next cycle.
- R8: Slots 3 and 5 to 15 are zero in the default list, which marks them unsupported. When any way selects such a slot, `cfg_err` is 1, and a way that selects one never matches.
- R9: An invalidate clears the entry that the invalidate address indexes in the selected way; later lookups of that page miss in that way.
- R10: `rsp_valid` follows `req_valid` one clock later. While `rsp_valid` is low, all result flags and `rsp_way_hits` are 0.
- R11: `rsp_way_hits` has bit n set exactly when way n matched the registered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the page-size configuration register |
| cfg_wdata | input | 4*min(NUM_WAYS,8) | New configuration, one 4-bit slot number per way |
| cfg_err | output | 1 | Some way selects an unsupported page size |
| wr_en | input | 1 | Write an entry |
| wr_way | input | WAY_W | Way to write |
| wr_va | input | VA_W | Virtual address of the page; also selects the entry index |
| wr_pa | input | PA_W | Physical address of the page |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_ca | input | CA_W | Attribute to store |
| inv_en | input | 1 | Invalidate an entry |
| inv_way | input | WAY_W | Way to invalidate |
| inv_va | input | VA_W | Address that selects the entry index to clear |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space tag |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_miss | output | 1 | No way matched |
| rsp_multihit | output | 1 | More than one way matched |
| rsp_way_hits | output | NUM_WAYS | Per-way match vector |
| rsp_pa | output | PA_W | Translated physical address (0 unless hit) |
| rsp_ca | output | CA_W | Attribute (0 unless hit) |

## Verification
The bench builds the block with its default parameters: four ways of four entries, 32-bit addresses, 8-bit tags and the default size list with a gap at slot 3. Four ways are enough to place the same page in two ways and force a multihit. They also let one way run with a 64 KiB page while the others keep 4 KiB pages. The gap at slot 3 makes the unsupported-size path reachable, along with its recovery once a supported slot is written back.

// File: rtl/tlb_match_pkg.sv
package tlb_match_pkg;

  localparam int LG_W     = 5;
  localparam int SLOTS    = 16;
  localparam int LIST_W   = SLOTS * LG_W;

  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MULTI = 2'd2
  } res_e;

  // log2 page size held in slot s of a packed size list (0 = unsupported)
  function automatic logic [LG_W-1:0] slot_lg(input logic [LIST_W-1:0] list,
                                              input logic [3:0] s);
    return list[s*LG_W +: LG_W];
  endfunction

  // ones in the bits below the page offset boundary
  function automatic logic [63:0] low_mask(input logic [LG_W-1:0] lg);
    return (64'd1 << lg) - 64'd1;
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_match_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int CA_W   = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LG_W-1:0]   page_lg,
  input  logic              size_ok,
  input  logic              wr_en,
  input  logic [VA_W-1:0]   wr_va,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [CA_W-1:0]   wr_ca,
  input  logic              inv_en,
  input  logic [VA_W-1:0]   inv_va,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              match,
  output logic [PA_W-1:0]   ent_pa,
  output logic [CA_W-1:0]   ent_ca
);

  localparam int ENT = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va,
                                              input logic [LG_W-1:0] lg);
    return IDX_W'(va >> lg);
  endfunction

  logic [ENT-1:0]    vld_q;
  logic [VA_W-1:0]   vpn_q  [ENT];
  logic [PA_W-1:0]   ppn_q  [ENT];
  logic [ASID_W-1:0] asid_q [ENT];
  logic [CA_W-1:0]   ca_q   [ENT];

  logic [VA_W-1:0]  va_mask;
  logic [PA_W-1:0]  pa_mask;
  logic [IDX_W-1:0] lk_idx, wr_idx, inv_idx;

  assign va_mask = VA_W'(low_mask(page_lg));
  assign pa_mask = PA_W'(low_mask(page_lg));
  assign lk_idx  = idx_of(lk_va,  page_lg);
  assign wr_idx  = idx_of(wr_va,  page_lg);
  assign inv_idx = idx_of(inv_va, page_lg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (wr_en)  vld_q[wr_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_va & ~va_mask;
      ppn_q[wr_idx]  <= wr_pa & ~pa_mask;
      asid_q[wr_idx] <= wr_asid;
      ca_q[wr_idx]   <= wr_ca;
    end
  end

  assign match = size_ok && vld_q[lk_idx] && (lk_asid != '0) &&
                 (asid_q[lk_idx] == lk_asid) &&
                 (((vpn_q[lk_idx] ^ lk_va) & ~va_mask) == '0);

  assign ent_pa = (ppn_q[lk_idx] & ~pa_mask) | (PA_W'(lk_va) & pa_mask);
  assign ent_ca = ca_q[lk_idx];

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_match_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PA_W     = 32,
  parameter int CA_W     = 4
) (
  input  logic [NUM_WAYS-1:0]      hits,
  input  logic [NUM_WAYS*PA_W-1:0] pa_vec,
  input  logic [NUM_WAYS*CA_W-1:0] ca_vec,
  output res_e                     kind,
  output logic [PA_W-1:0]          pa,
  output logic [CA_W-1:0]          ca
);

  logic [PA_W-1:0] pa_or;
  logic [CA_W-1:0] ca_or;

  always_comb begin
    pa_or = '0;
    ca_or = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hits[w]) begin
        pa_or = pa_or | pa_vec[w*PA_W +: PA_W];
        ca_or = ca_or | ca_vec[w*CA_W +: CA_W];
      end
    end
  end

  always_comb begin
    if (hits == '0)                 kind = RES_MISS;
    else if ($countones(hits) == 1) kind = RES_HIT;
    else                            kind = RES_MULTI;
  end

  assign pa = (kind == RES_HIT) ? pa_or : '0;
  assign ca = (kind == RES_HIT) ? ca_or : '0;

endmodule

// File: rtl/tlb_matcher.sv
module tlb_matcher
  import tlb_match_pkg::*;
#(
  parameter int NUM_WAYS     = 4,
  parameter int ENTRIES_LOG2 = 2,
  parameter int VA_W         = 32,
  parameter int PA_W         = 32,
  parameter int ASID_W       = 8,
  parameter int CA_W         = 4,
  parameter logic [LIST_W-1:0] SIZE_LIST = {55'd0, 5'd20, 5'd0, 5'd16, 5'd14, 5'd12},
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int CFG_WAYS = (NUM_WAYS < 8) ? NUM_WAYS : 8,
  localparam int CFG_W    = 4 * CFG_WAYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic                cfg_err,
  input  logic                wr_en,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic [VA_W-1:0]     wr_va,
  input  logic [PA_W-1:0]     wr_pa,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [CA_W-1:0]     wr_ca,
  input  logic                inv_en,
  input  logic [WAY_W-1:0]    inv_way,
  input  logic [VA_W-1:0]     inv_va,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_va,
  input  logic [ASID_W-1:0]   req_asid,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_multihit,
  output logic [NUM_WAYS-1:0] rsp_way_hits,
  output logic [PA_W-1:0]     rsp_pa,
  output logic [CA_W-1:0]     rsp_ca
);

  logic [CFG_W-1:0]  cfg_q;
  logic              req_vld_q;
  logic [VA_W-1:0]   req_va_q;
  logic [ASID_W-1:0] req_asid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      req_vld_q  <= 1'b0;
      req_va_q   <= '0;
      req_asid_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      req_vld_q <= req_valid;
      if (req_valid) begin
        req_va_q   <= req_va;
        req_asid_q <= req_asid;
      end
    end
  end

  // named per-way events for the checker
  logic [NUM_WAYS-1:0]      way_match;
  logic [NUM_WAYS-1:0]      bad_ways;
  logic [NUM_WAYS*PA_W-1:0] pa_vec;
  logic [NUM_WAYS*CA_W-1:0] ca_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [3:0]      slot;
    logic [LG_W-1:0] lg;
    if (w < 8) begin : g_cfg
      assign slot = cfg_q[4*w +: 4];
    end else begin : g_fixed
      assign slot = 4'd0;
    end
    assign lg          = slot_lg(SIZE_LIST, slot);
    assign bad_ways[w] = (lg == '0);

    tlb_way #(
      .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .CA_W(CA_W), .IDX_W(ENTRIES_LOG2)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .page_lg (lg),
      .size_ok (!bad_ways[w]),
      .wr_en   (wr_en  && (wr_way  == WAY_W'(w))),
      .wr_va   (wr_va),
      .wr_pa   (wr_pa),
      .wr_asid (wr_asid),
      .wr_ca   (wr_ca),
      .inv_en  (inv_en && (inv_way == WAY_W'(w))),
      .inv_va  (inv_va),
      .lk_va   (req_va_q),
      .lk_asid (req_asid_q),
      .match   (way_match[w]),
      .ent_pa  (pa_vec[w*PA_W +: PA_W]),
      .ent_ca  (ca_vec[w*CA_W +: CA_W])
    );
  end

  res_e            kind;
  logic [PA_W-1:0] res_pa;
  logic [CA_W-1:0] res_ca;

  tlb_resolve #(.NUM_WAYS(NUM_WAYS), .PA_W(PA_W), .CA_W(CA_W)) u_resolve (
    .hits   (way_match),
    .pa_vec (pa_vec),
    .ca_vec (ca_vec),
    .kind   (kind),
    .pa     (res_pa),
    .ca     (res_ca)
  );

  assign cfg_err      = |bad_ways;
  assign rsp_valid    = req_vld_q;
  assign rsp_hit      = req_vld_q && (kind == RES_HIT);
  assign rsp_miss     = req_vld_q && (kind == RES_MISS);
  assign rsp_multihit = req_vld_q && (kind == RES_MULTI);
  assign rsp_way_hits = req_vld_q ? way_match : '0;
  assign rsp_pa       = req_vld_q ? res_pa : '0;
  assign rsp_ca       = req_vld_q ? res_ca : '0;

endmodule

// File: rtl/tlb_matcher_chk.sv
module tlb_matcher_chk #(
  parameter int NUM_WAYS = 4,
  parameter int PA_W     = 32,
  parameter int CA_W     = 4,
  parameter int ASID_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_miss,
  input logic                rsp_multihit,
  input logic [NUM_WAYS-1:0] rsp_way_hits,
  input logic [PA_W-1:0]     rsp_pa,
  input logic [CA_W-1:0]     rsp_ca,
  input logic [ASID_W-1:0]   asid_q,
  input logic [NUM_WAYS-1:0] bad_ways
);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_multihit}) == 1); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_multihit) && rsp_way_hits == '0); // R10

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10

  AST_RSP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10

  AST_MULTI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multihit |-> rsp_pa == '0 && rsp_ca == '0 && $countones(rsp_way_hits) > 1); // R4

  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_pa == '0 && rsp_ca == '0 && rsp_way_hits == '0); // R3

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $countones(rsp_way_hits) == 1); // R11

  AST_ASID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && asid_q == '0) |-> rsp_way_hits == '0); // R5

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_way_hits & bad_ways) == '0); // R8

endmodule

bind tlb_matcher tlb_matcher_chk #(
  .NUM_WAYS(NUM_WAYS), .PA_W(PA_W), .CA_W(CA_W), .ASID_W(ASID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_multihit (rsp_multihit),
  .rsp_way_hits (rsp_way_hits),
  .rsp_pa       (rsp_pa),
  .rsp_ca       (rsp_ca),
  .asid_q       (req_asid_q),
  .bad_ways     (bad_ways)
);

// File: tb/test_tlb_matcher.sv
module test_tlb_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_err;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [31:0] wr_va = '0, wr_pa = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_ca = '0;
  logic        inv_en = 1'b0;
  logic [1:0]  inv_way = '0;
  logic [31:0] inv_va = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_multihit;
  logic [NW-1:0] rsp_way_hits;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_ca;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_matcher i_tlb_matcher (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
    .wr_en(wr_en), .wr_way(wr_way), .wr_va(wr_va), .wr_pa(wr_pa),
    .wr_asid(wr_asid), .wr_ca(wr_ca),
    .inv_en(inv_en), .inv_way(inv_way), .inv_va(inv_va),
    .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_multihit(rsp_multihit), .rsp_way_hits(rsp_way_hits),
    .rsp_pa(rsp_pa), .rsp_ca(rsp_ca)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] way, input logic [31:0] va, input logic [31:0] pa,
                     input logic [7:0] asid, input logic [3:0] ca);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_va = va; wr_pa = pa; wr_asid = asid; wr_ca = ca;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kill(input logic [1:0] way, input logic [31:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_way = way; inv_va = va;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // kind: 0 miss, 1 hit, 2 multihit
  task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                      input int kind, input logic [31:0] exp_pa, input logic [3:0] exp_ca,
                      input logic [NW-1:0] exp_hits);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "flags {hit,miss,multi}", 64'({rsp_hit, rsp_miss, rsp_multihit}),
        64'((kind == 1) ? 3'b100 : (kind == 0) ? 3'b010 : 3'b001));
    chk(req, "rsp_pa", 64'(rsp_pa), 64'(exp_pa));
    chk(req, "rsp_ca", 64'(rsp_ca), 64'(exp_ca));
    chk(req, "rsp_way_hits", 64'(rsp_way_hits), 64'(exp_hits));
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1", "cfg_err after reset", 64'(cfg_err), 64'd0);
    look("R1", 32'h0000_1000, 8'd1, 0, 32'h0, 4'h0, 4'b0000);
  endtask

  task automatic t_latency;
    @(negedge clk);
    chk("R10", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R10", "flags idle", 64'({rsp_hit, rsp_miss, rsp_multihit, rsp_way_hits}), 64'd0);
  endtask

  task automatic t_single_hit;
    put(2'd0, 32'h0001_2000, 32'h8004_5000, 8'd5, 4'h3);
    look("R2", 32'h0001_2ABC, 8'd5, 1, 32'h8004_5ABC, 4'h3, 4'b0001);
    look("R11", 32'h0001_2004, 8'd5, 1, 32'h8004_5004, 4'h3, 4'b0001);
  endtask

  task automatic t_miss;
    look("R3", 32'h0001_2ABC, 8'd6, 0, 32'h0, 4'h0, 4'b0000);
    look("R3", 32'h0005_2ABC, 8'd5, 0, 32'h0, 4'h0, 4'b0000);
    look("R3", 32'h0001_1ABC, 8'd5, 0, 32'h0, 4'h0, 4'b0000);
  endtask

  task automatic t_asid_zero;
    put(2'd2, 32'h0007_0000, 32'h0000_1000, 8'd0, 4'h1);
    look("R5", 32'h0007_0010, 8'd0, 0, 32'h0, 4'h0, 4'b0000);
  endtask

  task automatic t_index;
    put(2'd0, 32'h0001_3000, 32'h9000_0000, 8'd5, 4'h4);
    look("R6", 32'h0001_3010, 8'd5, 1, 32'h9000_0010, 4'h4, 4'b0001);
    look("R6", 32'h0001_2FFF, 8'd5, 1, 32'h8004_5FFF, 4'h3, 4'b0001);
  endtask

  task automatic t_multi;
    put(2'd1, 32'h0001_2000, 32'h7000_0000, 8'd5, 4'h6);
    look("R4", 32'h0001_2ABC, 8'd5, 2, 32'h0, 4'h0, 4'b0011);
  endtask

  task automatic t_invalidate;
    kill(2'd1, 32'h0001_2000);
    look("R9", 32'h0001_2ABC, 8'd5, 1, 32'h8004_5ABC, 4'h3, 4'b0001);
    kill(2'd0, 32'h0001_2FFF);
    look("R9", 32'h0001_2ABC, 8'd5, 0, 32'h0, 4'h0, 4'b0000);
    look("R9", 32'h0001_3010, 8'd5, 1, 32'h9000_0010, 4'h4, 4'b0001);
  endtask

  task automatic t_page_size;
    set_cfg(16'h2000);   // way 3 -> slot 2 (64 KiB)
    chk("R7", "cfg_err slot 2", 64'(cfg_err), 64'd0);
    put(2'd3, 32'h0034_0000, 32'hABC5_1234, 8'd7, 4'h9);
    look("R7", 32'h0034_F123, 8'd7, 1, 32'hABC5_F123, 4'h9, 4'b1000);
    look("R7", 32'h0035_0123, 8'd7, 0, 32'h0, 4'h0, 4'b0000);
  endtask

  task automatic t_bad_size;
    set_cfg(16'h3000);   // way 3 -> slot 3, unsupported
    chk("R8", "cfg_err slot 3", 64'(cfg_err), 64'd1);
    look("R8", 32'h0034_F123, 8'd7, 0, 32'h0, 4'h0, 4'b0000);
    set_cfg(16'h00F0);   // way 1 -> slot 15, unsupported
    chk("R8", "cfg_err slot 15", 64'(cfg_err), 64'd1);
    set_cfg(16'h2000);
    chk("R8", "cfg_err restored", 64'(cfg_err), 64'd0);
    look("R8", 32'h0034_0001, 8'd7, 1, 32'hABC5_0001, 4'h9, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_single_hit();
    t_miss();
    t_asid_zero();
    t_index();
    t_multi();
    t_invalidate();
    t_page_size();
    t_bad_size();
    t_latency();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule